// File: doc/BRIEF.md
# Latching Interrupt Status Controller

This block gathers 22 interrupt sources into two register banks on a 32-bit word bus. Each source can be inverted. Each bank then decides, bit by bit, whether to report the live level of the inverted source or a sticky flag. The flag is set when the inverted source goes from low to high, and it stays set until software clears it by writing a one to that bit of the acknowledge register.

Each bank ANDs its status with its own enable mask to form a masked status. It then ORs the masked status into one request line. Bank 0 drives the main request and bank 1 drives the secondary request. Both banks see the same sources, but they keep separate enable, mode and inversion storage. Each bank also has its own sticky flags.

The bus is synchronous. A write takes effect at the clock edge where the write strobe is high. Read data is registered: it appears in the cycle after the read strobe and is held until the next read. The byte address is word aligned. Address bit 5 selects the bank and bits 4:2 select the register:

| Index | Register |
|-------|----------|
| 0 | status |
| 1 | enable |
| 2 | acknowledge |
| 3 | mode |
| 4 | inversion |
| 5 | masked status |
| 6, 7 | reserved |

Top module: `irq_ctl_top`

## Requirements
- R1: After reset, each bank reads enable = 0x00003011, mode = 0x00000019, inversion = 0, status = 0 and masked status = 0, and both request lines are low.
- R2: For a bit whose mode bit is 0, status (index 0) shows the live value of source XOR inversion, with no register in the path.
- R3: For a bit whose mode bit is 1, status shows a flag. The flag is set at the first clock edge where source XOR inversion is high after having been low at the previous edge. The flag then stays set.
- R4: Setting an inversion bit makes a high-to-low source transition set the flag. Setting the inversion bit while the source is low counts as a rising edge of the inverted signal.
- R5: A write to the acknowledge register (index 2) clears every flag whose data bit is 1. Level-mode status bits are not changed by it, and the acknowledge register reads as zero.
- R6: When a write of one to the acknowledge register and a new edge hit the same flag at the same clock edge, the flag ends up set.
- R7: Masked status (index 5) equals status AND enable, and the request line of a bank is high exactly when that bank's masked status is non-zero.
- R8: Bits 31:22 of every register read as zero and ignore writes. Indexes 6 and 7 of both banks read as zero.
- R9: Bank 1 (address bit 5 = 1) has storage separate from bank 0. Only bank 0 drives irq_main, and only bank 1 drives irq_aux.
- R10: rdata updates only in the cycle after rd_en is high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 22 | Interrupt source levels, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address: bit 5 bank, bits 4:2 register index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_main | output | 1 | OR of bank 0 masked status |
| irq_aux | output | 1 | OR of bank 1 masked status |

## Verification
The checker watches every bit of bank 0 on every cycle. It confirms that an inverted rising edge always leaves the flag set, even when an acknowledge lands on the same edge. It confirms that a flag only drops when an acknowledge names it, and that an acknowledge without a competing edge does clear it. It also checks that the upper read bits stay zero, that read data holds between reads, and that the request lines go quiet when the enables are zero.

Some behaviours only the bench scenarios can show:
- the reset values;
- level bits passing through unaffected by acknowledge;
- a falling edge caught through inversion, including the edge created by the inversion write itself;
- reserved offsets reading zero;
- the two banks holding separate state and driving only their own request line.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned IDX_W = 3;

  typedef logic [IDX_W-1:0] reg_idx_t;

  localparam reg_idx_t IDX_STAT = 3'd0;
  localparam reg_idx_t IDX_EN   = 3'd1;
  localparam reg_idx_t IDX_ACK  = 3'd2;
  localparam reg_idx_t IDX_MODE = 3'd3;
  localparam reg_idx_t IDX_INV  = 3'd4;
  localparam reg_idx_t IDX_MSK  = 3'd5;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic inv_i,
  input  logic mode_i,
  input  logic ack_i,
  output logic eff_o,
  output logic prev_o,
  output logic flag_o,
  output logic stat_o
);
  logic eff;
  logic rise;
  logic prev_d, prev_q;
  logic flag_d, flag_q;

  assign eff  = src_i ^ inv_i;
  assign rise = eff & ~prev_q;

  always_comb begin
    prev_d = eff;
    flag_d = rise | (flag_q & ~ack_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign stat_o = mode_i ? flag_q : eff;
  assign eff_o  = eff;
  assign prev_o = prev_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_pkg::*;
#(
  parameter int unsigned     NSRC     = 22,
  parameter logic [NSRC-1:0] EN_RST   = NSRC'(32'h0000_3011),
  parameter logic [NSRC-1:0] MODE_RST = NSRC'(32'h0000_0019),
  parameter logic [NSRC-1:0] INV_RST  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic             wr_i,
  input  reg_idx_t         idx_i,
  input  logic [NSRC-1:0]  wdata_i,
  output logic [REG_W-1:0] rword_o,
  output logic [NSRC-1:0]  masked_o,
  output logic             ack_wr_o,
  output logic [NSRC-1:0]  eff_o,
  output logic [NSRC-1:0]  prev_o,
  output logic [NSRC-1:0]  flag_o
);
  localparam int unsigned PAD_W = REG_W - NSRC;

  logic [NSRC-1:0] en_d, en_q;
  logic [NSRC-1:0] mode_d, mode_q;
  logic [NSRC-1:0] inv_d, inv_q;
  logic [NSRC-1:0] ack;
  logic [NSRC-1:0] stat;
  logic            en_we, mode_we, inv_we;

  assign en_we    = wr_i && (idx_i == IDX_EN);
  assign mode_we  = wr_i && (idx_i == IDX_MODE);
  assign inv_we   = wr_i && (idx_i == IDX_INV);
  assign ack_wr_o = wr_i && (idx_i == IDX_ACK);
  assign ack      = ack_wr_o ? wdata_i : '0;

  always_comb begin
    en_d   = en_we   ? wdata_i : en_q;
    mode_d = mode_we ? wdata_i : mode_q;
    inv_d  = inv_we  ? wdata_i : inv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= EN_RST;
      mode_q <= MODE_RST;
      inv_q  <= INV_RST;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      inv_q  <= inv_d;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_cell
    irq_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i[i]),
      .inv_i  (inv_q[i]),
      .mode_i (mode_q[i]),
      .ack_i  (ack[i]),
      .eff_o  (eff_o[i]),
      .prev_o (prev_o[i]),
      .flag_o (flag_o[i]),
      .stat_o (stat[i])
    );
  end

  assign masked_o = stat & en_q;

  always_comb begin
    unique case (idx_i)
      IDX_STAT: rword_o = {{PAD_W{1'b0}}, stat};
      IDX_EN:   rword_o = {{PAD_W{1'b0}}, en_q};
      IDX_MODE: rword_o = {{PAD_W{1'b0}}, mode_q};
      IDX_INV:  rword_o = {{PAD_W{1'b0}}, inv_q};
      IDX_MSK:  rword_o = {{PAD_W{1'b0}}, masked_o};
      default:  rword_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_pkg::*;
#(
  parameter int unsigned NSRC   = 22,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq_main,
  output logic              irq_aux
);
  localparam int unsigned NBANK    = 2;
  localparam int unsigned IDX_LSB  = 2;
  localparam int unsigned BANK_BIT = ADDR_W - 1;

  logic                           rst_sync_n;
  reg_idx_t                       idx;
  logic                           bank_sel;
  logic [NBANK-1:0][REG_W-1:0]    rword;
  logic [NBANK-1:0][NSRC-1:0]     masked;
  logic [NBANK-1:0]               ack_wr;
  logic [NBANK-1:0][NSRC-1:0]     eff_w, prev_w, flag_w;
  logic [REG_W-1:0]               rdata_d, rdata_q;
  logic                           unused_bits;

  assign idx         = addr[IDX_LSB +: IDX_W];
  assign bank_sel    = addr[BANK_BIT];
  assign unused_bits = ^{addr[IDX_LSB-1:0], wdata[REG_W-1:NSRC]};

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irq_bank #(.NSRC(NSRC)) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .src_i    (src_i),
      .wr_i     (wr_en && (bank_sel == 1'(b))),
      .idx_i    (idx),
      .wdata_i  (wdata[NSRC-1:0]),
      .rword_o  (rword[b]),
      .masked_o (masked[b]),
      .ack_wr_o (ack_wr[b]),
      .eff_o    (eff_w[b]),
      .prev_o   (prev_w[b]),
      .flag_o   (flag_w[b])
    );
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rword[bank_sel];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign rdata    = rdata_q;
  assign irq_main = |masked[0];
  assign irq_aux  = |masked[1];
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int unsigned NSRC = 22
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en,
  input logic [31:0]     wdata,
  input logic [31:0]     rdata,
  input logic            ack0,
  input logic [NSRC-1:0] eff0,
  input logic [NSRC-1:0] prev0,
  input logic [NSRC-1:0] flag0,
  input logic [NSRC-1:0] en0,
  input logic [NSRC-1:0] en1,
  input logic            irq_main,
  input logic            irq_aux
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    // R3 R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eff0[i] && !prev0[i]) |=> flag0[i]);
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag0[i] && !(ack0 && wdata[i])) |=> flag0[i]);
    // R5
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack0 && wdata[i] && !(eff0[i] && !prev0[i])) |=> !flag0[i]);
  end

  // R8
  rdata_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:NSRC] == '0);
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  // R7 R9
  main_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en0 == '0) |-> !irq_main);
  // R7 R9
  aux_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en1 == '0) |-> !irq_aux);
endmodule

bind irq_ctl_top irq_ctl_chk #(.NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .rd_en    (rd_en),
  .wdata    (wdata),
  .rdata    (rdata),
  .ack0     (ack_wr[0]),
  .eff0     (eff_w[0]),
  .prev0    (prev_w[0]),
  .flag0    (flag_w[0]),
  .en0      (g_bank[0].u_bank.en_q),
  .en1      (g_bank[1].u_bank.en_q),
  .irq_main (irq_main),
  .irq_aux  (irq_aux)
);

// File: tb/sim_irq_ctl_top.sv
module sim_irq_ctl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_main, irq_aux;

  int nchk = 0, nerr = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_ctl_top u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_main(irq_main), .irq_aux(irq_aux)
  );

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_src(input int b, input logic v);
    @(negedge clk); src[b] = v;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    nchk++;
    if (act !== e) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) rd_d <= rd_en;

  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rdata, e, t);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [31:0] held;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(6'h04, 32'h3011, "R1 en0");
    rd(6'h0C, 32'h19,   "R1 mode0");
    rd(6'h10, 32'h0,    "R1 inv0");
    rd(6'h00, 32'h0,    "R1 stat0");
    rd(6'h14, 32'h0,    "R1 masked0");
    rd(6'h24, 32'h3011, "R1 en1");
    rd(6'h2C, 32'h19,   "R1 mode1");
    rd(6'h30, 32'h0,    "R1 inv1");
    #1;
    chk(irq_main, 0, "R1 irq_main");
    chk(irq_aux,  0, "R1 irq_aux");
    wr(6'h24, 32'h0);

    // R2 level pass-through, R7 masked, R9 main only
    set_src(12, 1'b1);
    rd(6'h00, 32'h1000, "R2 level stat");
    rd(6'h14, 32'h1000, "R7 masked");
    #1;
    chk(irq_main, 1, "R9 irq_main on");
    chk(irq_aux,  0, "R9 irq_aux off");
    // R5 ack leaves level bit alone
    wr(6'h08, 32'h1000);
    rd(6'h00, 32'h1000, "R5 level after ack");
    rd(6'h08, 32'h0,    "R5 ack reads zero");
    set_src(12, 1'b0);
    rd(6'h00, 32'h0, "R2 level drop");
    #1; chk(irq_main, 0, "R7 irq_main off");

    // R3 latched pulse
    set_src(0, 1'b1);
    set_src(0, 1'b0);
    rd(6'h00, 32'h1, "R3 latched hold");
    #1; chk(irq_main, 1, "R3 irq_main from flag");
    wr(6'h08, 32'h1);
    rd(6'h00, 32'h0, "R5 ack clears flag");

    // R4 inversion
    wr(6'h10, 32'h10);
    rd(6'h00, 32'h10, "R4 inversion write edge");
    wr(6'h08, 32'h10);
    rd(6'h00, 32'h0, "R4 cleared");
    set_src(4, 1'b1);
    rd(6'h00, 32'h0, "R4 rise ignored when inverted");
    set_src(4, 1'b0);
    rd(6'h00, 32'h10, "R4 fall captured");
    wr(6'h08, 32'h10);

    // R6 set wins over ack
    @(negedge clk); wr_en = 1'b1; addr = 6'h08; wdata = 32'h8; src[3] = 1'b1;
    @(negedge clk); wr_en = 1'b0; src[3] = 1'b0;
    rd(6'h00, 32'h8, "R6 set beats ack");

    // R7 mask
    wr(6'h04, 32'h0F);
    rd(6'h14, 32'h8, "R7 masked partial");
    wr(6'h04, 32'h0);
    rd(6'h14, 32'h0, "R7 masked zero");
    rd(6'h00, 32'h8, "R7 raw kept");
    #1; chk(irq_main, 0, "R7 irq_main masked off");

    // R8 upper bits and reserved offsets
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, 32'h003F_FFFF, "R8 upper bits");
    wr(6'h04, 32'h0);
    rd(6'h18, 32'h0, "R8 reserved 18");
    rd(6'h1C, 32'h0, "R8 reserved 1C");
    rd(6'h38, 32'h0, "R8 reserved 38");

    // R9 bank 1 independence
    wr(6'h2C, 32'h20);
    wr(6'h24, 32'h20);
    rd(6'h0C, 32'h19, "R9 mode0 untouched");
    set_src(5, 1'b1);
    set_src(5, 1'b0);
    rd(6'h00, 32'h8,  "R9 bank0 level bit5 low");
    rd(6'h20, 32'h20, "R9 bank1 flag");
    #1;
    chk(irq_aux,  1, "R9 irq_aux on");
    chk(irq_main, 0, "R9 irq_main stays off");
    wr(6'h28, 32'h20);
    #1; chk(irq_aux, 0, "R9 irq_aux after ack");

    // R10 read data holds
    rd(6'h2C, 32'h20, "R10 read mode1");
    drain();
    held = rdata;
    wr(6'h2C, 32'h0);
    set_src(0, 1'b1);
    set_src(0, 1'b0);
    drain();
    chk(rdata, held, "R10 rdata held");

    drain();
    finish_run();
  end
endmodule